// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

A single timer channel behind a small synchronous register bus. Software writes a start value, selects a counting mode, a counter width and a clock divider, and sets the run bit. The counter then steps down by one on every divided tick. When it arrives at zero it raises a level interrupt that stays up until software clears it.

Three counting modes are available. In free-running mode the counter wraps from zero to the largest value of the selected width. In periodic mode it reloads from the stored reload value. In one-shot mode it parks at zero. The counter can be 16 or 32 bits wide.

The reload value can be written in two ways. One register sets it and also loads the counter at once. A second register changes only the value used at the next reload and leaves the current count alone. The tick source is the bus clock qualified by `tick_en`, followed by a divide-by-1, 16 or 256 prescaler.

Top module: `interval_timer`

## Requirements
- R1: After reset the control register reads 0x20 (interrupt enable set, timer stopped, free-running, 16-bit), the reload value reads 0, raw and masked status read 0, `irq` is low, and the count holds all ones (reading 0x0000FFFF in 16-bit mode).
- R2: Register word addresses are: 0 reload-and-load, 1 count (read-only), 2 control, 3 interrupt clear, 4 raw status (bit 0), 5 masked status (bit 0), 6 reload-only. Address 7 and address 3 read zero. The control bits are: 7 run, 6 periodic, 5 interrupt enable, 3:2 divider, 1 wide (32-bit), 0 one-shot. Control reads back as written in bits 7:0.
- R3: With bit 1 of control clear, only the low 16 bits of the counter take part, and the count reads with bits 31:16 zero. The reload value still reads back in full.
- R4: A write to address 0 loads the counter on the same clock edge and sets the reload value. Writes to address 1 change nothing.
- R5: When a decrement is due at zero, the counter behaves by mode. If the one-shot bit is set, it stays at zero, and one-shot takes priority over periodic. Otherwise, in periodic mode it reloads. Otherwise it wraps to 0xFFFF (16-bit) or 0xFFFFFFFF (32-bit).
- R6: The counter decreases by one per prescaled tick, and only while the run bit is set. Prescaled ticks are counted only on cycles with `tick_en` high. Divider code 01 divides by 16, code 10 divides by 256, and codes 00 and 11 divide by 1.
- R7: Any control write restarts the prescaler phase, so the first divided tick comes a full divider period after that write.
- R8: A decrement from 1 to 0 sets the raw flag. A write to address 3 clears it. When both occur in the same cycle, the flag stays set.
- R9: `irq` and the masked status both equal the raw flag ANDed with interrupt enable.
- R10: A write to address 6 changes the reload value without touching the current count. The new value is used at the next periodic reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Qualifies clock cycles as timer cycles |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe, one register per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, raw flag gated by enable |

## Verification
The checker assumes that the bus carries at most one write per cycle and that a read address is held steady while its data is sampled. It also assumes `tick_en` may take any value in any cycle. The hold properties rely on control and reload writes being the only things that move the counter while it is stopped. The stimulus respects these assumptions: it issues single-cycle writes from tasks, samples read data one nanosecond after setting the address, and stops the timer before any reconfiguration whose edge could otherwise add a tick. It also drives `tick_en` both held and toggling.

// File: rtl/interval_timer_pkg.sv
package interval_timer_pkg;

    localparam int DATA_W   = 32;
    localparam int NARROW_W = 16;
    localparam int ADDR_W   = 3;
    localparam int PRESC_W  = 8;

    typedef enum logic [ADDR_W-1:0] {
        A_LOAD   = 3'd0,
        A_COUNT  = 3'd1,
        A_CTRL   = 3'd2,
        A_ICLR   = 3'd3,
        A_RAW    = 3'd4,
        A_MASK   = 3'd5,
        A_BGLOAD = 3'd6,
        A_NONE   = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        DIV1   = 2'd0,
        DIV16  = 2'd1,
        DIV256 = 2'd2,
        DIV1B  = 2'd3
    } psel_e;

    typedef struct packed {
        logic  en;
        logic  periodic;
        logic  ie;
        logic  spare;
        psel_e psel;
        logic  wide;
        logic  oneshot;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam ctrl_t CTRL_RST = '{en: 1'b0, periodic: 1'b0, ie: 1'b1, spare: 1'b0,
                                   psel: DIV1, wide: 1'b0, oneshot: 1'b0};

    typedef struct packed {
        logic load_wr;
        logic ctrl_wr;
        logic iclr_wr;
        logic bg_wr;
    } wr_dec_t;

    // Terminal phase of the prescaler for each divider code.
    function automatic logic [PRESC_W-1:0] presc_last(psel_e s);
        case (s)
            DIV16:   return PRESC_W'(15);
            DIV256:  return PRESC_W'(255);
            default: return '0;
        endcase
    endfunction

    // Bits of the counter that take part at the selected width.
    function automatic logic [DATA_W-1:0] width_mask(logic wide);
        return wide ? {DATA_W{1'b1}} : {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    endfunction

endpackage

// File: rtl/itmr_regfile.sv
module itmr_regfile
    import interval_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              zero_evt,
    output ctrl_t             ctrl_q,
    output logic [DATA_W-1:0] reload_q,
    output logic              raw_q,
    output wr_dec_t           dec
);

    always_comb begin
        dec = '0;
        if (we) begin
            case (reg_addr_e'(addr))
                A_LOAD:   dec.load_wr = 1'b1;
                A_CTRL:   dec.ctrl_wr = 1'b1;
                A_ICLR:   dec.iclr_wr = 1'b1;
                A_BGLOAD: dec.bg_wr   = 1'b1;
                default:  dec = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= CTRL_RST;
            reload_q <= '0;
            raw_q    <= 1'b0;
        end else begin
            if (dec.ctrl_wr)
                ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (dec.load_wr || dec.bg_wr)
                reload_q <= wdata;
            // A zero arrival outranks a clear in the same cycle.
            if (zero_evt)
                raw_q <= 1'b1;
            else if (dec.iclr_wr)
                raw_q <= 1'b0;
        end
    end

endmodule

// File: rtl/itmr_prescaler.sv
module itmr_prescaler
    import interval_timer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick_en,
    input  logic  run,
    input  logic  restart,
    input  psel_e psel,
    output logic  pulse
);

    logic [PRESC_W-1:0] phase_q;
    logic               step;

    assign step  = tick_en && run;
    assign pulse = step && (phase_q == presc_last(psel));

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (restart)
            phase_q <= '0;
        else if (step)
            phase_q <= pulse ? '0 : phase_q + PRESC_W'(1);
    end

endmodule

// File: rtl/itmr_counter.sv
module itmr_counter
    import interval_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pulse,
    input  logic              wide,
    input  logic              oneshot,
    input  logic              periodic,
    input  logic              load_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] reload_val,
    output logic [DATA_W-1:0] count_eff,
    output logic              zero_evt
);

    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] count_d;
    logic              at_zero;

    assign mask      = width_mask(wide);
    assign count_eff = count_q & mask;
    assign at_zero   = (count_eff == '0);
    assign zero_evt  = pulse && (count_eff == DATA_W'(1));

    always_comb begin
        count_d = count_q;
        if (load_wr) begin
            count_d = wdata;
        end else if (pulse) begin
            if (!at_zero)
                count_d = count_eff - DATA_W'(1);
            else if (oneshot)
                count_d = count_q;
            else if (periodic)
                count_d = reload_val;
            else
                count_d = mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= {DATA_W{1'b1}};
        else
            count_q <= count_d;
    end

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import interval_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] reload_q;
    logic              raw_q;
    wr_dec_t           dec;
    logic              pulse;
    logic [DATA_W-1:0] cnt_eff;
    logic              zero_evt;
    logic              masked;

    itmr_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .we       (bus_we),
        .wdata    (bus_wdata),
        .zero_evt (zero_evt),
        .ctrl_q   (ctrl_q),
        .reload_q (reload_q),
        .raw_q    (raw_q),
        .dec      (dec)
    );

    itmr_prescaler u_presc (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .run     (ctrl_q.en),
        .restart (dec.ctrl_wr),
        .psel    (ctrl_q.psel),
        .pulse   (pulse)
    );

    itmr_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .pulse      (pulse),
        .wide       (ctrl_q.wide),
        .oneshot    (ctrl_q.oneshot),
        .periodic   (ctrl_q.periodic),
        .load_wr    (dec.load_wr),
        .wdata      (bus_wdata),
        .reload_val (reload_q),
        .count_eff  (cnt_eff),
        .zero_evt   (zero_evt)
    );

    assign masked = raw_q && ctrl_q.ie;
    assign irq    = masked;

    always_comb begin
        case (reg_addr_e'(bus_addr))
            A_LOAD, A_BGLOAD: bus_rdata = reload_q;
            A_COUNT:          bus_rdata = cnt_eff;
            A_CTRL:           bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            A_RAW:            bus_rdata = {{(DATA_W-1){1'b0}}, raw_q};
            A_MASK:           bus_rdata = {{(DATA_W-1){1'b0}}, masked};
            default:          bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/interval_timer_checker.sv
module interval_timer_checker
    import interval_timer_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              ctrl_en,
    input logic              ctrl_oneshot,
    input logic              ctrl_wide,
    input logic [DATA_W-1:0] count_eff,
    input logic              raw,
    input logic              zero_evt
);

    assert_load_immediate_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_LOAD) |=> (count_eff == ($past(bus_wdata) & width_mask(ctrl_wide))));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        zero_evt |=> raw);

    assert_clear_drops_irq_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_ICLR && !zero_evt) |=> (!raw && !irq));

    assert_stopped_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_en && !(bus_we && (bus_addr == A_LOAD || bus_addr == A_CTRL))) |=> $stable(count_eff));

    assert_oneshot_parks_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_en && ctrl_oneshot && count_eff == '0 && !bus_we) |=> (count_eff == '0));

    assert_narrow_read_R3: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_wide && bus_addr == A_COUNT) |-> (bus_rdata[DATA_W-1:NARROW_W] == '0));

    assert_mask_matches_irq_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_MASK) |-> (bus_rdata == {{(DATA_W-1){1'b0}}, irq}));

endmodule

bind interval_timer interval_timer_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .irq          (irq),
    .ctrl_en      (ctrl_q.en),
    .ctrl_oneshot (ctrl_q.oneshot),
    .ctrl_wide    (ctrl_q.wide),
    .count_eff    (cnt_eff),
    .raw          (raw_q),
    .zero_evt     (zero_evt)
);

// File: tb/interval_timer_tb.sv
`timescale 1ns/1ps
module interval_timer_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick_en;
    logic [2:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    interval_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Starts just after an edge, ends just after the edge that takes the write.
    task automatic wr(int a, logic [31:0] d);
        bus_addr  = 3'(a);
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
    endtask

    task automatic chk_rd(string req, int a, logic [31:0] exp);
        bus_addr = 3'(a);
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        rst = 1'b1; tick_en = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk_rd("R1 ctrl", 2, 32'h20);
        chk_rd("R1 count", 1, 32'h0000FFFF);
        chk_rd("R1 load", 0, 32'h0);
        chk_rd("R1 raw", 4, 32'h0);
        chk_rd("R1 masked", 5, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        chk_rd("R2 unused addr", 7, 32'h0);

        // R2/R3 wide mode exposes the all-ones count
        wr(2, 32'h22);
        chk_rd("R2 ctrl readback", 2, 32'h22);
        chk_rd("R3 wide count", 1, 32'hFFFFFFFF);

        // R4 count writes ignored, load writes immediate
        wr(1, 32'h1234);
        chk_rd("R4 count write ignored", 1, 32'hFFFFFFFF);
        wr(0, 32'hABCD0004);
        chk_rd("R4 load immediate", 1, 32'hABCD0004);
        wr(2, 32'h20);
        chk_rd("R3 narrow count", 1, 32'h00000004);
        chk_rd("R3 load full", 0, 32'hABCD0004);
        chk_rd("R2 bgload readback", 6, 32'hABCD0004);
        chk_rd("R2 iclr reads zero", 3, 32'h0);

        // R5/R6/R8/R9 sweep over divider, mode and start value
        for (int ps = 0; ps < 4; ps++) begin
            for (int md = 0; md < 4; md++) begin
                for (int li = 0; li < 2; li++) begin
                    int unsigned L;
                    int unsigned dv;
                    int unsigned ev;
                    int unsigned D;
                    logic [31:0] cw;
                    logic [31:0] exp_cnt;
                    logic        exp_raw;
                    L  = (li == 0) ? 3 : 9;
                    dv = (ps == 1) ? 16 : (ps == 2) ? 256 : 1;
                    ev = (dv == 256) ? dv * 5 + 3 : dv * 13 + 5;
                    D  = ev / dv;
                    case (md)
                        0: cw = 32'h00;
                        1: cw = 32'h02;
                        2: cw = 32'h42;
                        default: cw = 32'h43;
                    endcase
                    cw = cw | 32'hA0 | (32'(ps) << 2);
                    wr(2, 32'h0);
                    wr(3, 32'h0);
                    wr(0, L);
                    wr(2, cw);
                    edges(ev);
                    case (md)
                        0: exp_cnt = (L - D) & 32'hFFFF;
                        1: exp_cnt = L - D;
                        2: exp_cnt = L - (D % (L + 1));
                        default: exp_cnt = (D >= L) ? 32'h0 : L - D;
                    endcase
                    exp_raw = (D >= L);
                    chk_rd($sformatf("R5 R6 count ps=%0d mode=%0d L=%0d", ps, md, L), 1, exp_cnt);
                    chk_rd($sformatf("R8 raw ps=%0d mode=%0d L=%0d", ps, md, L), 4, {31'b0, exp_raw});
                    chk_rd($sformatf("R9 masked ps=%0d mode=%0d L=%0d", ps, md, L), 5, {31'b0, exp_raw});
                    check($sformatf("R9 irq ps=%0d mode=%0d L=%0d", ps, md, L), {31'b0, irq}, {31'b0, exp_raw});
                end
            end
        end

        // R6 tick_en gating
        wr(2, 32'h0);
        wr(0, 100);
        tick_en = 1'b0;
        wr(2, 32'hA2);
        edges(10);
        chk_rd("R6 tick_en low holds", 1, 32'd100);
        for (int i = 0; i < 12; i++) begin
            tick_en = (i % 2 == 0);
            @(posedge clk);
            #1;
        end
        tick_en = 1'b1;
        chk_rd("R6 half-rate ticks", 1, 32'd94);

        // R7 control write restarts the prescaler phase
        wr(2, 32'h0);
        wr(0, 50);
        wr(2, 32'hA6);
        edges(10);
        wr(2, 32'hA6);
        edges(15);
        chk_rd("R7 no tick before full period", 1, 32'd50);
        edges(1);
        chk_rd("R7 tick after full period", 1, 32'd49);

        // R10 background reload
        wr(2, 32'h0);
        wr(3, 32'h0);
        wr(0, 3);
        wr(2, 32'hE2);
        edges(1);
        wr(6, 6);
        chk_rd("R10 count undisturbed", 1, 32'd1);
        chk_rd("R10 reload readback", 0, 32'd6);
        edges(1);
        chk_rd("R8 raw at zero", 4, 32'h1);
        edges(1);
        chk_rd("R10 new reload used", 1, 32'd6);

        // R8 set wins over clear in the same cycle
        wr(2, 32'h0);
        wr(3, 32'h0);
        wr(0, 2);
        wr(2, 32'hE2);
        edges(1);
        wr(3, 32'h0);
        chk_rd("R8 set wins", 4, 32'h1);
        wr(3, 32'h0);
        chk_rd("R8 clear", 4, 32'h0);

        // R9 masking by interrupt enable
        wr(2, 32'h02);
        wr(3, 32'h0);
        wr(0, 1);
        wr(2, 32'h82);
        edges(1);
        chk_rd("R9 raw set unmasked", 4, 32'h1);
        chk_rd("R9 masked zero with ie off", 5, 32'h0);
        check("R9 irq low with ie off", {31'b0, irq}, 32'h0);
        wr(2, 32'hA2);
        check("R9 irq high with ie on", {31'b0, irq}, 32'h1);
        chk_rd("R9 masked one with ie on", 5, 32'h1);
        wr(3, 32'h0);
        check("R8 irq low after clear", {31'b0, irq}, 32'h0);
        wr(2, 32'h0);

        summary();
    end

endmodule